// File: doc/BRIEF.md
# Expansion Bus Interrupt Status Latch

This block collects interrupt requests from an expansion bus that has seven numbered request lines and one non-maskable line. Each line passes through a synchronizer, and a rising edge on a line latches a pending flag for it. The flags appear to the host as one byte-wide status value with active-low bits. All pending flags together drive a single shared interrupt output. On that interrupt the host reads the status byte to find which source fired.

The host acknowledges one source per write. It writes the bit position of that source as a small number, not as a mask. A line that stays high after its acknowledge does not raise its flag again. The line must fall and rise again to do so.

Top module: `bus_irq_status_latch`

## Requirements
- R1: Input `req_i[n]` for n from 0 to 6 maps to status bit 6-n. The non-maskable input `req_i[7]` maps to status bit 7.
- R2: A status bit on `rd_data_o` reads 0 while its source is pending and 1 while it is not.
- R3: A write (`cs_i`=1 and `we_i`=1 at a rising clock edge) clears only the status bit whose position equals `wr_data_i[2:0]`. No other pending bit changes.
- R4: The write data bits `wr_data_i[7:3]` are ignored.
- R5: Only a rising edge of a synchronized request sets its flag. A request that stays high after its flag is cleared leaves the bit at 1 until the request goes low and then rises again.
- R6: If a new rising edge and a clear write hit the same bit in the same cycle, the bit stays pending.
- R7: `irq_o` is 1 exactly when at least one status bit reads 0. It lags the status by one clock cycle.
- R8: After reset `rd_data_o` is 8'hFF and `irq_o` is 0.
- R9: A request that goes high just after a clock edge shows on its status bit after the third following rising edge, and not after the second.
- R10: A write with `cs_i`=0 or with `we_i`=0 changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register select |
| we_i | input | 1 | Write strobe, qualified by `cs_i` |
| wr_data_i | input | 8 | Write data; the low three bits give the bit to clear |
| rd_data_o | output | 8 | Active-low status byte |
| req_i | input | 8 | Raw requests; [6:0] numbered, [7] non-maskable |
| irq_o | output | 1 | Shared interrupt output to the host |

## Verification
The bench raises each line alone. This checks the bit mapping, the exact three-edge latency and the one-cycle lag of the interrupt output. Then it sweeps all 256 combinations of simultaneous requests. Each combination tells apart mapping errors that single lines cannot show. Each combination is then cleared one index at a time, with changing junk in the upper write bits, to show that every clear hits exactly one bit. Separate sequences cover a request held high across its clear, a clear in the same cycle as a new edge, and writes that lack the select or the strobe.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  // Status bit position of a request line: the last line (non-maskable)
  // takes the top bit, the numbered lines fill the rest in reversed order.
  function automatic int unsigned line_to_bit(input int unsigned line,
                                              input int unsigned n_lines);
    if (line == n_lines - 1)
      return n_lines - 1;
    return n_lines - 2 - line;
  endfunction

  // One-hot clear vector from an index.
  function automatic logic [31:0] index_onehot(input int unsigned idx);
    logic [31:0] v;
    v = '0;
    v[idx[4:0]] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              sync_out;

  assign sync_out = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], req_i};
      prev_q <= sync_out;
    end
  end

  assign rise_o = sync_out & ~prev_q;

  // A detected edge lasts one cycle only (R5)
  p_rise_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/irq_clear_decode.sv
module irq_clear_decode #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic             cs_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] clr_o
);
  import irq_status_pkg::*;

  logic             wr_hit;
  logic [IDX_W-1:0] clr_idx;
  logic [31:0]      onehot;

  assign wr_hit  = cs_i & we_i;
  assign clr_idx = wr_data_i[IDX_W-1:0];
  assign onehot  = index_onehot(32'(clr_idx));

  always_comb begin
    clr_o = '0;
    if (wr_hit)
      clr_o = onehot[WIDTH-1:0];
  end

endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] pend_q;
  logic [WIDTH-1:0] pend_d;

  // Set has priority over clear (R6)
  assign pend_d = (pend_q & ~clr_i) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(set_i)) == $past(set_i)));

  p_only_edge_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_i)) == '0));

  p_clear_takes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  p_one_bit_drops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones($past(pend_q) & ~pend_q) <= 1));

endmodule

// File: rtl/bus_irq_status_latch.sv
module bus_irq_status_latch #(
  parameter int unsigned N_LINES     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_i,
  input  logic               we_i,
  input  logic [N_LINES-1:0] wr_data_i,
  output logic [N_LINES-1:0] rd_data_o,
  input  logic [N_LINES-1:0] req_i,
  output logic               irq_o
);
  import irq_status_pkg::*;

  logic [N_LINES-1:0] rise_line;  // edges in line order
  logic [N_LINES-1:0] set_bits;   // edges in status bit order
  logic [N_LINES-1:0] clr_bits;
  logic [N_LINES-1:0] pend_bits;
  logic               any_pend;
  logic               irq_q;

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    localparam int unsigned BIT = line_to_bit(n, N_LINES);
    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_i[n]),
      .rise_o (rise_line[n])
    );
    assign set_bits[BIT] = rise_line[n];
  end

  irq_clear_decode #(.WIDTH(N_LINES)) u_dec (
    .cs_i      (cs_i),
    .we_i      (we_i),
    .wr_data_i (wr_data_i),
    .clr_o     (clr_bits)
  );

  irq_pending_bank #(.WIDTH(N_LINES)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_bits),
    .clr_i  (clr_bits),
    .pend_o (pend_bits)
  );

  assign any_pend  = |pend_bits;
  assign rd_data_o = ~pend_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= any_pend;
  end
  assign irq_o = irq_q;

  p_irq_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(rd_data_o != '1)));

  p_idle_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(cs_i && we_i) && set_bits == '0) |=> (rd_data_o == $past(rd_data_o)));

endmodule

// File: tb/bus_irq_status_latch_bench.sv
`timescale 1ns/1ps
module bus_irq_status_latch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] req = '0;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  bus_irq_status_latch u_bus_irq_status_latch (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we),
    .wr_data_i(wdata), .rd_data_o(rdata), .req_i(req), .irq_o(irq));

  // Expected status: reverse the low seven request bits, keep bit 7, invert.
  function automatic logic [7:0] exp_status(input logic [7:0] m);
    logic [6:0] rev;
    for (int i = 0; i < 7; i++) rev[i] = m[6 - i];
    return ~{m[7], rev};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, input logic c, input logic w);
    cs = c; we = w; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0; wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R8 status", rdata, 8'hFF);
    chk("R8 irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    step(2);

    // Single lines: mapping, latency, irq lag, clear by index, held high
    for (int n = 0; n < 8; n++) begin
      logic [7:0] m;
      logic [2:0] b;
      m = 8'(1) << n;
      b = (n == 7) ? 3'd7 : 3'(6 - n);
      req = m;
      step(2);
      chk("R9 not yet", rdata, 8'hFF);
      step(1);
      chk("R1 R2 R9 mapping", rdata, exp_status(m));
      chk("R7 lag", {7'b0, irq}, 8'h00);
      step(1);
      chk("R7 irq", {7'b0, irq}, 8'h01);
      wr({5'(n * 5 + 3), b}, 1'b1, 1'b0);
      chk("R10 no strobe", rdata, exp_status(m));
      wr({5'(n * 5 + 3), b}, 1'b0, 1'b1);
      chk("R10 no select", rdata, exp_status(m));
      wr({5'(n * 7 + 9), b}, 1'b1, 1'b1);
      chk("R3 R4 clear", rdata, 8'hFF);
      step(1);
      chk("R7 irq off", {7'b0, irq}, 8'h00);
      step(5);
      chk("R5 held high", rdata, 8'hFF);
      req = '0;
      step(4);
    end

    // Set beats clear in the same cycle
    req = 8'h04;               // line 2 -> bit 4
    step(4);
    req = 8'h00;
    step(4);
    req = 8'h04;
    step(2);                   // edge now visible inside, takes effect next edge
    wr(8'h04, 1'b1, 1'b1);
    chk("R6 set wins", rdata, exp_status(8'h04));
    wr(8'h04, 1'b1, 1'b1);
    chk("R6 then clears", rdata, 8'hFF);
    req = 8'h00;
    step(4);

    // Fall then rise re-arms
    req = 8'h40;
    step(4);
    wr(8'h00, 1'b1, 1'b1);
    req = 8'h00;
    step(3);
    req = 8'h40;
    step(4);
    chk("R5 re-arm", rdata, exp_status(8'h40));
    wr(8'hF8, 1'b1, 1'b1);
    chk("R4 upper ignored", rdata, 8'hFF);
    req = 8'h00;
    step(4);

    // All combinations, cleared one index at a time
    for (int m = 0; m < 256; m++) begin
      logic [7:0] st;
      req = 8'(m);
      step(4);
      st = exp_status(8'(m));
      chk("R1 R2 combo", rdata, st);
      chk("R7 combo irq", {7'b0, irq}, {7'b0, (m != 0)});
      req = '0;
      for (int k = 0; k < 8; k++) begin
        wr({5'(m + k), 3'(k)}, 1'b1, 1'b1);
        st[k] = 1'b1;
        chk("R3 one bit", rdata, st);
      end
      step(1);
      chk("R7 combo off", {7'b0, irq}, 8'h00);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule